// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of an 8-bit microcontroller's multiplexed external memory bus. The first is an active-high address latch strobe, which tells an external latch to capture the low address byte. The second is an active-low program read strobe, which enables external code memory onto the bus.

All timing comes from the oscillator clock. A divide-by-two flop splits each state into two phases. A state counter then walks six states, so one machine cycle lasts twelve oscillator clocks.

At the last clock of each machine cycle, the block samples four per-cycle controls from the core:
- whether code runs from external memory;
- whether the coming cycle is an external data transfer;
- whether the coming cycle is a code-table read;
- a control bit that quiets the address strobe.

These sampled values shape the strobes of the next machine cycle. The core uses the phase, state and cycle-start outputs to line up its own sequencing.

Top module: `bus_strobe_seq`

## Requirements
- R1: Bus positions are numbered 0 to 11 from reset. Each oscillator clock moves one position forward, and the count wraps from 11 to 0. At each position, `phase_p2` equals position mod 2 and `state_idx` equals position/2. `cyc_start` is 1 only at position 0.
- R2: In a plain machine cycle, `addr_latch_stb` is 1 at positions 1, 2, 7 and 8 and 0 everywhere else. This gives two pulses per machine cycle, each two clocks wide.
- R3: When external execution is set and the cycle is not a data transfer, `prog_rd_n` is 0 at positions 4, 5, 10 and 11 and 1 elsewhere. This gives two pulses per machine cycle.
- R4: When external execution is clear, `prog_rd_n` stays 1 for the whole machine cycle.
- R5: In an external data-transfer cycle, the first address-strobe pulse (positions 1 and 2) is left out. The pulse at positions 7 and 8 still appears.
- R6: In an external data-transfer cycle, both program-read pulses are left out, so `prog_rd_n` stays 1 for the cycle.
- R7: Take a cycle with the quiet bit set, external execution clear, and neither the data-transfer flag nor the code-table flag set. In that cycle `addr_latch_stb` is held at 1 for all twelve positions.
- R8: With the quiet bit set, a data-transfer cycle or a code-table cycle still strobes exactly as R2 and R5 describe.
- R9: The quiet bit has no effect while external execution is set.
- R10: The four controls are sampled on the clock edge that moves position 11 to position 0, and they govern the cycle that begins there. Changes at any other time have no effect on the strobes.
- R11: Reset is synchronous and active high. After reset the block is at position 0 with all sampled controls clear, so `addr_latch_stb` = 0 and `prog_rd_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Code is fetched from external memory |
| xdata_cyc | input | 1 | Next cycle is an external data transfer |
| ctab_cyc | input | 1 | Next cycle is a code-table read |
| latch_quiet | input | 1 | Quiets the address strobe outside bus-transfer cycles |
| addr_latch_stb | output | 1 | Address latch strobe, active high |
| prog_rd_n | output | 1 | Program memory read strobe, active low |
| state_idx | output | 3 | Current state, 0 to 5 |
| phase_p2 | output | 1 | 1 in the second phase of a state |
| cyc_start | output | 1 | First clock of a machine cycle |

## Verification
Two functions can apply to the same machine cycle: the pulse skipping of a data-transfer cycle and the quiet bit. The quiet bit can also meet external execution in one cycle. Directed cycles set each of these pairs on purpose, and random cycles pick all four controls at random, so the overlaps recur many times. Between sample points the bench also toggles the controls, to show that only the value present at the cycle boundary counts. At every clock a bench model of position and sampled controls predicts both strobes. Per-cycle counts of strobe-active clocks are compared as well.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int NUM_PHASES = 2;
    localparam int NUM_STATES = 6;
    localparam int ST_W       = $clog2(NUM_STATES);

    // states that open each strobe window
    localparam int LATCH_A_ST = 0;
    localparam int LATCH_B_ST = 3;
    localparam int READ_A_ST  = 2;
    localparam int READ_B_ST  = 5;

    typedef enum logic {PH1 = 1'b0, PH2 = 1'b1} phase_e;

    typedef struct packed {
        logic [ST_W-1:0] st;
        phase_e          ph;
    } slot_t;

    typedef struct packed {
        logic ext_exec;
        logic xdata;
        logic ctab;
        logic quiet;
    } cyc_cfg_t;

    typedef struct packed {
        logic hold_high;
        logic latch_a_en;
        logic latch_b_en;
        logic read_en;
    } gate_t;

    typedef struct packed {
        logic latch_a;
        logic latch_b;
        logic read_win;
    } win_t;

    function automatic logic in_span(slot_t s, int first_st);
        return ((int'(s.st) == first_st) && (s.ph == PH2)) ||
               ((int'(s.st) == first_st + 1) && (s.ph == PH1));
    endfunction

    function automatic win_t decode_slot(slot_t s);
        win_t w;
        w.latch_a  = in_span(s, LATCH_A_ST);
        w.latch_b  = in_span(s, LATCH_B_ST);
        w.read_win = (int'(s.st) == READ_A_ST) || (int'(s.st) == READ_B_ST);
        return w;
    endfunction

    function automatic gate_t cfg_to_gate(cyc_cfg_t c);
        gate_t g;
        logic  allow;
        allow        = !c.quiet || c.ext_exec || c.xdata || c.ctab;
        g.hold_high  = !allow;
        g.latch_a_en = allow && !c.xdata;
        g.latch_b_en = allow;
        g.read_en    = c.ext_exec && !c.xdata;
        return g;
    endfunction
endpackage

// File: rtl/bss_clock_div.sv
module bss_clock_div
    import bss_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst) phase <= PH1;
        else     phase <= (phase == PH1) ? PH2 : PH1;
    end

    assert_phase_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase != $past(phase));
endmodule

// File: rtl/bss_state_ctr.sv
module bss_state_ctr
    import bss_pkg::*;
#(
    parameter int STATES = NUM_STATES
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    output logic [ST_W-1:0] st,
    output logic            cyc_first,
    output logic            cyc_last
);
    localparam logic [ST_W-1:0] LAST_ST = ST_W'(STATES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (phase == PH2)
            st <= (st == LAST_ST) ? '0 : st + 1'b1;
    end

    always_comb begin
        cyc_first = (st == '0) && (phase == PH1);
        cyc_last  = (st == LAST_ST) && (phase == PH2);
    end

    assert_state_bound_R1: assert property (@(posedge clk) disable iff (rst)
        st <= LAST_ST);
    assert_state_step_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH2 && st != LAST_ST) |=> st == ST_W'($past(st) + 1'b1));
    assert_state_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_last |=> cyc_first);
endmodule

// File: rtl/bss_cfg_latch.sv
module bss_cfg_latch
    import bss_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cyc_last,
    input  cyc_cfg_t cfg_in,
    output gate_t    gate
);
    cyc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)           cfg_q <= '0;
        else if (cyc_last) cfg_q <= cfg_in;
    end

    always_comb gate = cfg_to_gate(cfg_q);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cyc_last |=> $stable(cfg_q));
endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
    import bss_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t slot,
    input  gate_t gate,
    output logic  latch_stb,
    output logic  read_n
);
    win_t win;

    always_comb begin
        win       = decode_slot(slot);
        latch_stb = gate.hold_high
                  | (win.latch_a & gate.latch_a_en)
                  | (win.latch_b & gate.latch_b_en);
        read_n    = !(win.read_win & gate.read_en);
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(latch_stb && !read_n));
    assert_read_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(read_n) |=> !read_n);
    assert_latch_width_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(latch_stb) && !gate.hold_high) |=> latch_stb);
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
    import bss_pkg::*;
#(
    parameter int STATES = NUM_STATES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_exec,
    input  logic            xdata_cyc,
    input  logic            ctab_cyc,
    input  logic            latch_quiet,
    output logic            addr_latch_stb,
    output logic            prog_rd_n,
    output logic [ST_W-1:0] state_idx,
    output logic            phase_p2,
    output logic            cyc_start
);
    phase_e          phase;
    logic [ST_W-1:0] st;
    logic            cyc_first;
    logic            cyc_last;
    cyc_cfg_t        cfg_in;
    gate_t           gate;
    slot_t           slot;

    always_comb begin
        cfg_in.ext_exec = ext_exec;
        cfg_in.xdata    = xdata_cyc;
        cfg_in.ctab     = ctab_cyc;
        cfg_in.quiet    = latch_quiet;
        slot.st         = st;
        slot.ph         = phase;
    end

    bss_clock_div u_div (.clk(clk), .rst(rst), .phase(phase));

    bss_state_ctr #(.STATES(STATES)) u_ctr (
        .clk(clk), .rst(rst), .phase(phase),
        .st(st), .cyc_first(cyc_first), .cyc_last(cyc_last)
    );

    bss_cfg_latch u_cfg (
        .clk(clk), .rst(rst), .cyc_last(cyc_last),
        .cfg_in(cfg_in), .gate(gate)
    );

    bss_strobe_gen u_stb (
        .clk(clk), .rst(rst), .slot(slot), .gate(gate),
        .latch_stb(addr_latch_stb), .read_n(prog_rd_n)
    );

    assign state_idx = st;
    assign phase_p2  = (phase == PH2);
    assign cyc_start = cyc_first;

    assert_int_no_read_R4: assert property (@(posedge clk) disable iff (rst)
        (cyc_last && !ext_exec) |=> prog_rd_n);
endmodule

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_exec = 1'b0, xdata_cyc = 1'b0, ctab_cyc = 1'b0, latch_quiet = 1'b0;
    logic       addr_latch_stb, prog_rd_n, phase_p2, cyc_start;
    logic [2:0] state_idx;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    int  pos;
    logic [3:0] cfg;
    logic [3:0] pend;
    int  latch_hi_cnt, read_lo_cnt;

    always #2 clk = ~clk;

    bus_strobe_seq u_dut (
        .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_cyc(xdata_cyc),
        .ctab_cyc(ctab_cyc), .latch_quiet(latch_quiet),
        .addr_latch_stb(addr_latch_stb), .prog_rd_n(prog_rd_n),
        .state_idx(state_idx), .phase_p2(phase_p2), .cyc_start(cyc_start)
    );

    // cfg bits: [3] ext_exec, [2] xdata, [1] ctab, [0] quiet
    function automatic logic exp_latch(int p, logic [3:0] c);
        logic allow;
        allow = !c[0] || c[3] || c[2] || c[1];
        if (!allow) return 1'b1;
        if ((p == 1 || p == 2) && !c[2]) return 1'b1;
        if (p == 7 || p == 8) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_read_n(int p, logic [3:0] c);
        if (c[3] && !c[2] && (p == 4 || p == 5 || p == 10 || p == 11)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_latch_cnt(logic [3:0] c);
        int n = 0;
        for (int p = 0; p < 12; p++) n += int'(exp_latch(p, c));
        return n;
    endfunction

    function automatic int exp_read_cnt(logic [3:0] c);
        int n = 0;
        for (int p = 0; p < 12; p++) n += int'(!exp_read_n(p, c));
        return n;
    endfunction

    function automatic string req_of(logic [3:0] c);
        if (c[0] && !c[3] && !c[2] && !c[1]) return "R7";
        if (c[0] && c[3]) return "R9";
        if (c[0]) return "R8";
        if (c[2]) return "R5/R6";
        if (c[3]) return "R3";
        return "R2/R4";
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s pos=%0d cfg=%b actual=%0d expected=%0d", req, pos, cfg, act, exp);
        end
    endtask

    task automatic sample_all();
        check("R1", int'(state_idx), pos / 2);
        check("R1", int'(phase_p2), pos % 2);
        check("R1", int'(cyc_start), int'(pos == 0));
        check({req_of(cfg), " R10"}, int'(addr_latch_stb), int'(exp_latch(pos, cfg)));
        check({req_of(cfg), " R10"}, int'(prog_rd_n), int'(exp_read_n(pos, cfg)));
        latch_hi_cnt += int'(addr_latch_stb);
        read_lo_cnt  += int'(!prog_rd_n);
    endtask

    task automatic drive(logic [3:0] v);
        ext_exec = v[3]; xdata_cyc = v[2]; ctab_cyc = v[1]; latch_quiet = v[0];
    endtask

    // runs one machine cycle under cfg; final value nxt is presented for the boundary
    task automatic run_cycle(logic [3:0] nxt, bit noisy);
        latch_hi_cnt = 0;
        read_lo_cnt  = 0;
        for (int k = 0; k < 12; k++) begin
            sample_all();
            if (pos == 11) begin
                check({req_of(cfg), " count"}, latch_hi_cnt, exp_latch_cnt(cfg));
                check({req_of(cfg), " count"}, read_lo_cnt, exp_read_cnt(cfg));
                drive(nxt);
                pend = nxt;
            end else if (noisy) begin
                drive(4'($urandom_range(0, 15)));   // R10: ignored mid-cycle
            end
            @(negedge clk);
            pos = (pos + 1) % 12;
            if (pos == 0) cfg = pend;
        end
    endtask

    initial begin
        logic [3:0] directed [8];
        void'($urandom(32'd4711));
        directed[0] = 4'b0000; directed[1] = 4'b1000; directed[2] = 4'b1100;
        directed[3] = 4'b0001; directed[4] = 4'b0011; directed[5] = 4'b0101;
        directed[6] = 4'b1001; directed[7] = 4'b1111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pos = 0;
        cfg = 4'b0000;
        pend = 4'b0000;
        // R11: reset state
        check("R11", int'(state_idx), 0);
        check("R11", int'(addr_latch_stb), 0);
        check("R11", int'(prog_rd_n), 1);
        drive(4'b1111);   // R10: not sampled, first boundary gets directed[0]
        run_cycle(directed[0], 1'b0);
        for (int i = 0; i < 8; i++)
            run_cycle((i < 7) ? directed[i + 1] : 4'($urandom_range(0, 15)), 1'b0);
        for (int i = 0; i < 300; i++)
            run_cycle(4'($urandom_range(0, 15)), (i % 2) == 1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule